// File: doc/BRIEF.md
# Four-Register Serial Bus Slave with Command Pointer

This block is the serial-bus front end of a small register file holding four 8-bit registers. It takes the SCL and SDA bus lines, oversampled in the system clock domain, and cleans each line with a two-flop synchronizer. A 3-sample majority vote follows, then a persistence counter, so pulses shorter than `GLITCH_CYC` system clocks never reach the protocol logic. It detects START, repeated START and STOP, and matches a 7-bit slave address built from the fixed upper nibble `0100` and three strap inputs. It tracks each byte of a transfer and pulls SDA low through an open-drain enable to acknowledge bytes and to shift out read data.

The first byte after a write address is a command byte. Its two low bits are loaded into a register pointer. That pointer never advances by itself and survives from one transaction to the next. Data bytes in a write transaction each produce a one-cycle write strobe with the pointer index and the byte. A read transaction raises a one-cycle read strobe for every byte the master asks for. The external register file must present the indexed register on `rd_data_i` in the cycle that strobe is high, and the byte is then shifted out MSB first.

The byte engine has these states. IDLE: the bus is free. ADDR: address byte reception. ADDR_ACK: address acknowledge. CMD: command byte reception. CMD_ACK: command acknowledge. WDATA: write data reception. WDATA_ACK: write data acknowledge. RDATA: read data transmission. RDATA_ACK: master acknowledge slot. IGNORE: not addressed, or the read was ended by a NACK.

START sends every state to ADDR, and STOP sends every state to IDLE; START is checked first. The other transitions all happen on a falling SCL edge:
- ADDR goes to ADDR_ACK after the eighth bit on an address match, and to IGNORE otherwise.
- ADDR_ACK goes to RDATA when the R/W bit was 1, and to CMD when it was 0.
- CMD goes to CMD_ACK after the eighth bit, and CMD_ACK goes to WDATA.
- WDATA goes to WDATA_ACK after the eighth bit, and WDATA_ACK goes back to WDATA.
- RDATA goes to RDATA_ACK after the eighth bit.
- RDATA_ACK goes to RDATA when the master acknowledged, and to IGNORE when it did not.

Top module: `i2cp_slave`

## Requirements
- R1: After reset the SDA pull-down enable is 0, both strobes are 0 and the register index is 0.
- R2: The slave acknowledges (SDA pulled low in the ninth clock) only an address byte whose upper seven bits equal `0100` followed by `strap_i[2:0]`, with bit 0 as R/W (0 = write, 1 = read). For any other address it drives nothing and issues no strobe until the next START.
- R3: In a write transaction the byte after the address is a command byte. It is always acknowledged, and its bits [1:0] become the register index; a command value above 3 is masked to those two bits.
- R4: Each data byte after the command byte in the same write transaction is acknowledged and produces exactly one single-cycle `wr_stb_o`, with `wr_data_o` equal to the byte and `reg_idx_o` equal to the pointer. Several bytes all go to the same register. A command byte alone produces no write strobe. The write is committed on the rising SCL edge of the ninth clock.
- R5: With R/W = 1, each byte sent by the slave comes from the pointed register, MSB first, and is preceded by one single-cycle `rd_stb_o`. A master ACK (SDA low in the ninth clock) requests the next byte. After a NACK the slave leaves SDA released until the next START.
- R6: The pointer does not auto-increment and keeps its value across STOP and START, so reads without a new command byte keep returning the same register. It changes only when a command byte is acknowledged.
- R7: A STOP at any point returns the slave to idle. A byte that was only partly received when the STOP arrived is discarded: no strobe, and no pointer change.
- R8: A pulse shorter than `GLITCH_CYC` system clocks (default 10, which is 50 ns at 200 MHz) on either SCL or SDA has no effect on the transfer.
- R9: The SDA pull-down enable changes only while the filtered SCL is low.
- R10: A repeated START in the middle of a byte abandons that byte without a strobe and restarts address reception.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset, returns every register and the byte engine to default |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap_i | input | 3 | Low three bits of the slave address |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| wr_stb_o | output | 1 | One-cycle write request toward the register file |
| wr_data_o | output | 8 | Byte to be written |
| rd_stb_o | output | 1 | One-cycle read request; `rd_data_i` is sampled in this cycle |
| reg_idx_o | output | 2 | Register pointer, index for both reads and writes |
| rd_data_i | input | 8 | Contents of the indexed register |

## Verification
Bus-condition detection and the byte engine can both act in the same SCL-high phase: a START or STOP can be seen while the bit counter holds a partly received byte, and the condition must win over the shift. The bench provokes this by issuing a STOP after four bits of a data byte, a STOP after five bits of a command byte, and a repeated START after three bits of a data byte. It judges each case by the write-strobe count, the register index and a read-back of the target register. A second overlap exists between a read strobe and the loading of the transmit shifter from the register file. It is checked by reading a register several times in a row and by confirming that SDA stays released on the clock that follows a NACK.

// File: rtl/i2cp_pkg.sv
`timescale 1ns/1ps
package i2cp_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } i2cp_state_e;

endpackage

// File: rtl/i2cp_line_filter.sv
`timescale 1ns/1ps
// Synchronizer, 3-sample majority vote and persistence counter for one bus line.
module i2cp_line_filter #(
    parameter int   GLITCH_CYC = 10,
    parameter logic RST_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CNT_W = $clog2(GLITCH_CYC + 1);

    logic [1:0]       sync_q;
    logic [2:0]       hist_q;
    logic             maj;
    logic             filt_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RST_VAL}};
            hist_q <= {3{RST_VAL}};
        end else begin
            sync_q <= {sync_q[0], raw_i};
            hist_q <= {hist_q[1:0], sync_q[1]};
        end
    end

    assign maj = (hist_q[0] & hist_q[1]) | (hist_q[1] & hist_q[2]) | (hist_q[0] & hist_q[2]);

    // The output follows the vote only after it has disagreed for GLITCH_CYC cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= RST_VAL;
            cnt_q  <= '0;
        end else if (maj != filt_q) begin
            if (cnt_q == CNT_W'(GLITCH_CYC - 1)) begin
                filt_q <= maj;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

    assign filt_o = filt_q;
endmodule

// File: rtl/i2cp_cond_det.sv
`timescale 1ns/1ps
// Edge and bus-condition detection on the filtered lines.
module i2cp_cond_det (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
        end
    end

    assign scl_rise_o = scl_f_i & ~scl_q;
    assign scl_fall_o = ~scl_f_i & scl_q;
    assign start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
    assign stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
endmodule

// File: rtl/i2cp_byte_fsm.sv
`timescale 1ns/1ps
// Byte engine: address match, command pointer, write/read strobes, SDA drive.
module i2cp_byte_fsm
    import i2cp_pkg::*;
#(
    parameter int                          ADDR_W     = 7,
    parameter int                          STRAP_W    = 3,
    parameter logic [ADDR_W-STRAP_W-1:0]   ADDR_FIXED = 4'b0100,
    parameter int                          IDX_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               start_i,
    input  logic               stop_i,
    input  logic               sda_f_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [BYTE_W-1:0]  rd_data_i,
    output logic               sda_pull_o,
    output logic               wr_stb_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               rd_stb_o,
    output logic [IDX_W-1:0]   reg_idx_o,
    output i2cp_state_e        state_o
);
    localparam int BCNT_W = $clog2(BYTE_W + 1);

    i2cp_state_e         st_q, st_d;
    logic [BCNT_W-1:0]   bit_cnt_q;
    logic [BYTE_W-1:0]   shift_q;
    logic [BYTE_W-1:0]   wr_data_q;
    logic [IDX_W-1:0]    ptr_q;
    logic                rw_q;
    logic                mack_q;
    logic                wr_stb_q;
    logic                rd_stb_q;
    logic                byte_done;
    logic                addr_hit;

    assign byte_done = (bit_cnt_q == BCNT_W'(BYTE_W));
    assign addr_hit  = (shift_q[BYTE_W-1:1] == {ADDR_FIXED, strap_i});

    // Next-state logic
    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d = ST_ADDR;
        end else if (stop_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_IGNORE: st_d = st_q;
                ST_ADDR:      if (scl_fall_i && byte_done) st_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall_i) st_d = rw_q ? ST_RDATA : ST_CMD;
                ST_CMD:       if (scl_fall_i && byte_done) st_d = ST_CMD_ACK;
                ST_CMD_ACK:   if (scl_fall_i) st_d = ST_WDATA;
                ST_WDATA:     if (scl_fall_i && byte_done) st_d = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall_i) st_d = ST_WDATA;
                ST_RDATA:     if (scl_fall_i && byte_done) st_d = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall_i) st_d = mack_q ? ST_RDATA : ST_IGNORE;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Datapath and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shift_q   <= '0;
            wr_data_q <= '0;
            ptr_q     <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            wr_stb_q  <= 1'b0;
            rd_stb_q  <= 1'b0;
        end else begin
            wr_stb_q <= 1'b0;
            rd_stb_q <= 1'b0;
            if (start_i || stop_i) begin
                bit_cnt_q <= '0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (scl_rise_i && !byte_done) begin
                            shift_q   <= {shift_q[BYTE_W-2:0], sda_f_i};
                            bit_cnt_q <= bit_cnt_q + 1'b1;
                        end
                        if (scl_fall_i && byte_done) begin
                            bit_cnt_q <= '0;
                            if (st_q == ST_ADDR) rw_q <= shift_q[0];
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_rise_i && rw_q) rd_stb_q <= 1'b1;
                    end
                    ST_CMD_ACK: begin
                        if (scl_rise_i) ptr_q <= shift_q[IDX_W-1:0];
                    end
                    ST_WDATA_ACK: begin
                        if (scl_rise_i) begin
                            wr_stb_q  <= 1'b1;
                            wr_data_q <= shift_q;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise_i && !byte_done) bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (scl_fall_i) begin
                            if (byte_done) bit_cnt_q <= '0;
                            else           shift_q   <= {shift_q[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_rise_i) begin
                            mack_q <= ~sda_f_i;
                            if (!sda_f_i) rd_stb_q <= 1'b1;
                        end
                    end
                    ST_IDLE, ST_IGNORE: bit_cnt_q <= '0;
                    default: bit_cnt_q <= '0;
                endcase
            end
            // Register file answers in the strobe cycle; capture for transmission.
            if (rd_stb_q) shift_q <= rd_data_i;
        end
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            ST_ADDR_ACK, ST_CMD_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                              sda_pull_o = ~shift_q[BYTE_W-1];
            default:                               sda_pull_o = 1'b0;
        endcase
        wr_stb_o  = wr_stb_q;
        wr_data_o = wr_data_q;
        rd_stb_o  = rd_stb_q;
        reg_idx_o = ptr_q;
        state_o   = st_q;
    end
endmodule

// File: rtl/i2cp_slave.sv
`timescale 1ns/1ps
module i2cp_slave
    import i2cp_pkg::*;
#(
    parameter int                        GLITCH_CYC = 10,
    parameter int                        ADDR_W     = 7,
    parameter int                        STRAP_W    = 3,
    parameter logic [ADDR_W-STRAP_W-1:0] ADDR_FIXED = 4'b0100,
    parameter int                        IDX_W      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_pull_o,
    output logic               wr_stb_o,
    output logic [BYTE_W-1:0]  wr_data_o,
    output logic               rd_stb_o,
    output logic [IDX_W-1:0]   reg_idx_o,
    input  logic [BYTE_W-1:0]  rd_data_i
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] filt_lines;
    logic               scl_filt;
    logic               sda_filt;
    logic               scl_rise;
    logic               scl_fall;
    logic               start_det;
    logic               stop_det;
    i2cp_state_e        fsm_state;

    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_filt
        i2cp_line_filter #(
            .GLITCH_CYC (GLITCH_CYC),
            .RST_VAL    (1'b1)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_lines[g]),
            .filt_o (filt_lines[g])
        );
    end

    assign scl_filt = filt_lines[1];
    assign sda_filt = filt_lines[0];

    i2cp_cond_det u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f_i    (scl_filt),
        .sda_f_i    (sda_filt),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2cp_byte_fsm #(
        .ADDR_W     (ADDR_W),
        .STRAP_W    (STRAP_W),
        .ADDR_FIXED (ADDR_FIXED),
        .IDX_W      (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_f_i    (sda_filt),
        .strap_i    (strap_i),
        .rd_data_i  (rd_data_i),
        .sda_pull_o (sda_pull_o),
        .wr_stb_o   (wr_stb_o),
        .wr_data_o  (wr_data_o),
        .rd_stb_o   (rd_stb_o),
        .reg_idx_o  (reg_idx_o),
        .state_o    (fsm_state)
    );
endmodule

// File: rtl/i2cp_slave_chk.sv
`timescale 1ns/1ps
module i2cp_slave_chk
    import i2cp_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_stb,
    input logic             rd_stb,
    input logic [IDX_W-1:0] reg_idx,
    input logic             sda_pull,
    input logic             scl_filt,
    input logic             start_det,
    input logic             stop_det,
    input i2cp_state_e      state
);
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb)); // R4

    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R4

    AST_WR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(state) == ST_WDATA_ACK)); // R4

    AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb); // R5

    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx != $past(reg_idx)) |-> ($past(state) == ST_CMD_ACK)); // R6

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE)); // R7

    AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_filt); // R9

    AST_START_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR)); // R10
endmodule

bind i2cp_slave i2cp_slave_chk #(.IDX_W(IDX_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb_o),
    .rd_stb    (rd_stb_o),
    .reg_idx   (reg_idx_o),
    .sda_pull  (sda_pull_o),
    .scl_filt  (scl_filt),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (fsm_state)
);

// File: tb/i2cp_slave_tb_top.sv
`timescale 1ns/1ps
module i2cp_slave_tb_top;
    localparam int H = 50;
    localparam int Q = 25;
    localparam logic [2:0] STRAP = 3'b011;
    localparam logic [7:0] AW = {4'b0100, STRAP, 1'b0};
    localparam logic [7:0] AR = {4'b0100, STRAP, 1'b1};
    // {command byte, data byte}
    localparam logic [15:0] VEC [5] = '{16'h005A, 16'h01C3, 16'h020F, 16'h03F0, 16'h06A5};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n;
    logic       m_scl, m_sda;
    logic       sda_pull, wr_stb, rd_stb;
    logic [7:0] wr_data, rd_data;
    logic [1:0] reg_idx;
    logic       sda_line;
    logic [7:0] bregs [4];
    int         wr_cnt, rd_cnt;
    logic [7:0] last_wd;
    logic [1:0] last_idx;
    logic [7:0] exp_regs [4];
    int         n_chk = 0, n_err = 0;
    bit         done = 0;

    assign sda_line = m_sda & ~sda_pull;
    assign rd_data  = bregs[reg_idx];

    i2cp_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(STRAP),
        .sda_pull_o(sda_pull), .wr_stb_o(wr_stb), .wr_data_o(wr_data),
        .rd_stb_o(rd_stb), .reg_idx_o(reg_idx), .rd_data_i(rd_data)
    );

    // Register-file model driven by the strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) bregs[i] <= 8'h00;
            wr_cnt <= 0; rd_cnt <= 0; last_wd <= 8'h00; last_idx <= 2'd0;
        end else begin
            if (wr_stb) begin
                bregs[reg_idx] <= wr_data;
                wr_cnt <= wr_cnt + 1; last_wd <= wr_data; last_idx <= reg_idx;
            end
            if (rd_stb) rd_cnt <= rd_cnt + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b0; tick(H); m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(H); m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bit(input logic b);
        m_sda = b; tick(Q); m_scl = 1'b1; tick(H); m_scl = 1'b0; tick(Q);
    endtask

    // Same bit with a short SCL pulse in the low phase and, for a 1, a short SDA dip in the high phase
    task automatic send_bit_glitch(input logic b);
        m_sda = b; tick(5); m_scl = 1'b1; tick(6); m_scl = 1'b0; tick(Q - 11);
        m_scl = 1'b1; tick(20);
        if (b) begin m_sda = 1'b0; tick(6); m_sda = 1'b1; tick(24); end
        else tick(30);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_bit(output logic b);
        m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(H/2); b = sda_line; tick(H - H/2); m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        recv_bit(a);
        acked = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit ack);
        for (int i = 7; i >= 0; i--) recv_bit(v[i]);
        send_bit(!ack);
    endtask

    task automatic read_cmd(input logic [7:0] cmd, output logic [7:0] v);
        bit a0, a1, a2;
        bus_start(); send_byte(AW, a0); send_byte(cmd, a1);
        bus_start(); send_byte(AR, a2); recv_byte(v, 1'b0); bus_stop();
    endtask

    task automatic read_plain(output logic [7:0] v);
        bit a0;
        bus_start(); send_byte(AR, a0); recv_byte(v, 1'b0); bus_stop();
    endtask

    initial begin
        bit a0, a1, a2, a3;
        logic [7:0] rb, rb2, cmd, dat;
        logic lb;
        int w0, r0;
        m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
        for (int i = 0; i < 4; i++) exp_regs[i] = 8'h00;
        tick(10); rst_n = 1'b1; tick(20);

        // R1 reset state
        chk(sda_pull == 1'b0, "R1 pull after reset", sda_pull, 0);
        chk(wr_stb == 1'b0 && rd_stb == 1'b0, "R1 strobes after reset", {wr_stb, rd_stb}, 0);
        chk(reg_idx == 2'd0, "R1 index after reset", reg_idx, 0);

        // Vector table: write through a command, then read back through a repeated START
        for (int k = 0; k < 5; k++) begin
            cmd = VEC[k][15:8]; dat = VEC[k][7:0];
            w0 = wr_cnt;
            bus_start(); send_byte(AW, a0); send_byte(cmd, a1); send_byte(dat, a2); bus_stop();
            exp_regs[cmd[1:0]] = dat;
            chk(a0 && a1 && a2, "R2 R3 R4 acks on write", {a0, a1, a2}, 3'b111);
            chk(wr_cnt == w0 + 1, "R4 one write strobe", wr_cnt - w0, 1);
            chk(last_wd == dat && last_idx == cmd[1:0], "R4 write data and index",
                {last_idx, last_wd}, {cmd[1:0], dat});
            chk(reg_idx == cmd[1:0], "R3 pointer masked to two bits", reg_idx, cmd[1:0]);
            r0 = rd_cnt;
            read_cmd(cmd, rb);
            chk(rb == dat, "R5 read back MSB first", rb, dat);
            chk(rd_cnt == r0 + 1, "R5 one read strobe", rd_cnt - r0, 1);
        end

        // R3: command byte alone moves the pointer, no write
        w0 = wr_cnt;
        bus_start(); send_byte(AW, a0); send_byte(8'h04, a1); bus_stop();
        chk(a1 && reg_idx == 2'd0, "R3 command 04 masks to index 0", reg_idx, 0);
        chk(wr_cnt == w0, "R4 command-only writes nothing", wr_cnt - w0, 0);

        // R6 persistent pointer, R5 ACK continues and NACK releases
        r0 = rd_cnt;
        bus_start(); send_byte(AR, a0); recv_byte(rb, 1'b1); recv_byte(rb2, 1'b0);
        recv_bit(lb); bus_stop();
        chk(rb == exp_regs[0] && rb2 == exp_regs[0], "R6 repeated reads same register",
            {rb, rb2}, {exp_regs[0], exp_regs[0]});
        chk(rd_cnt == r0 + 2, "R5 strobe per byte", rd_cnt - r0, 2);
        chk(lb == 1'b1, "R5 SDA released after NACK", lb, 1);

        // R2 foreign address ignored
        w0 = wr_cnt;
        bus_start(); send_byte({4'b0100, 3'b010, 1'b0}, a0); send_byte(8'h01, a1); bus_stop();
        chk(!a0 && !a1, "R2 foreign address not acknowledged", {a0, a1}, 0);
        chk(wr_cnt == w0 && reg_idx == 2'd0, "R2 foreign address no effect", {wr_cnt - w0, reg_idx}, 0);

        // R4 several data bytes go to one register
        w0 = wr_cnt;
        bus_start(); send_byte(AW, a0); send_byte(8'h01, a1); send_byte(8'h11, a2); send_byte(8'h22, a3); bus_stop();
        exp_regs[1] = 8'h22;
        chk(a2 && a3 && wr_cnt == w0 + 2, "R4 two bytes two strobes", wr_cnt - w0, 2);
        chk(last_idx == 2'd1 && last_wd == 8'h22, "R4 same register", {last_idx, last_wd}, {2'd1, 8'h22});
        read_plain(rb);
        chk(rb == 8'h22, "R6 read without command", rb, 8'h22);

        // R7 STOP after four data bits
        w0 = wr_cnt;
        bus_start(); send_byte(AW, a0); send_byte(8'h03, a1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_stop();
        chk(wr_cnt == w0 && reg_idx == 2'd3, "R7 partial data byte discarded", wr_cnt - w0, 0);
        read_plain(rb);
        chk(rb == exp_regs[3], "R7 register unchanged", rb, exp_regs[3]);

        // R7 STOP after five command bits
        bus_start(); send_byte(AW, a0);
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        bus_stop();
        chk(reg_idx == 2'd3, "R7 partial command discarded", reg_idx, 3);

        // R10 repeated START in the middle of a data byte
        w0 = wr_cnt;
        bus_start(); send_byte(AW, a0); send_byte(8'h00, a1);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        bus_start(); send_byte(AR, a2); recv_byte(rb, 1'b0); bus_stop();
        chk(a2 && wr_cnt == w0, "R10 no strobe after repeated START", wr_cnt - w0, 0);
        chk(rb == exp_regs[0], "R10 read after repeated START", rb, exp_regs[0]);

        // R8 short pulses on both lines during a data byte
        w0 = wr_cnt;
        bus_start(); send_byte(AW, a0); send_byte(8'h02, a1);
        for (int i = 7; i >= 0; i--) send_bit_glitch(dat_b5(i));
        recv_bit(lb); bus_stop();
        exp_regs[2] = 8'hB5;
        chk(!lb && wr_cnt == w0 + 1, "R8 byte with glitches accepted once", wr_cnt - w0, 1);
        chk(last_wd == 8'hB5 && last_idx == 2'd2, "R8 glitches did not corrupt data", last_wd, 8'hB5);
        read_cmd(8'h02, rb);
        chk(rb == 8'hB5, "R8 read back after glitches", rb, 8'hB5);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    function automatic logic dat_b5(input int i);
        logic [7:0] v;
        v = 8'hB5;
        return v[i];
    endfunction

    initial begin
        tick(180000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule